// File: doc/BRIEF.md
# Disc Controller Indexed Register Bank

This block is the byte-wide register file that a host processor uses to steer a disc data controller. The host loads a small index pointer, then issues read or write strobes. Each access reaches the register the pointer selects, and afterwards the pointer moves to the next index. Index 0 is a parking slot, so the pointer stays there. Through this bank the host programs a transfer byte count and start address. It can also set a write address, a block pointer and two decoder control bytes. It reads back interface status, the latched block header or sub-header, and several decoder status bytes.

The transfer engine and the block decoder sit outside the bank. The engine sees a start pulse, the count and the address, and it answers with a done strobe. The decoder presents a header word and a sub-header word together with a strobe. Two active-low flags in the interface status byte record a finished transfer and a ready decoder block. The interface control byte masks them into a single active-low interrupt line. A host-side enable turns each new assertion of that line into a pending level, and the host clears that level. The decoder flag is also retired by a hold timer once it is stale.

Top module: `disc_reg_bank`

## Requirements
- R1: After a read or write strobe, the index pointer advances by one and wraps at 2^IDX_W, so 15 goes to 0 when IDX_W=4. It does not advance while it holds 0. Asserting `idx_load` replaces the pointer with `idx_val`.
- R2: After reset the read values are as follows. Index 1 (interface status) reads 0xFF. Header byte 3 (index 7) reads 0x01. Index 15 reads 0x80. Every other implemented index reads 0x00. `irq_n` is 1, and `host_pend` and `xfer_start` are 0.
- R3: Status bit 6 is transfer-end pending and bit 5 is decoder pending, both active low. Control bit 6 enables the transfer-end source and bit 5 enables the decoder source. `irq_n` is 0 exactly when (status6 is 0 and control6 is 1) or (status5 is 0 and control5 is 1).
- R4: `host_pend` becomes 1 one clock after `irq_n` goes from 1 to 0 while `host_en` is 1. It stays 0 if `host_en` is 0. `host_clr` sets it back to 0.
- R5: A write to index 6 while control bit 1 (data-output enable) is 1 clears status bits 3 (busy) and 2 (transfer enabled). It also raises `xfer_start` for exactly one clock. With control bit 1 at 0, the write has no effect.
- R6: A write to index 1 stores the control byte. If bit 1 of the written byte is 0, status bits 3 and 2 are forced to 1, which aborts the transfer.
- R7: A `xfer_done` strobe sets status bits 3 and 2 to 1 and clears bit 6. A write to index 7 sets bit 6 back to 1.
- R8: Indexes 2 and 3 hold the byte count, and only the low 4 bits of index 3 are kept. Indexes 4 and 5 hold the address. `xfer_cnt` is {cnt_hi[3:0], cnt_lo} and `xfer_addr` is {adr_hi, adr_lo}. A read of index 0, or of any index at or above 16, returns 0xFF. A read of index 13 returns 0x00.
- R9: A `dec_strobe` while control-0 bit 7 is 1 latches `dec_hdr` and `dec_sub`, writes 0x00 to the index-15 byte, and clears status bit 5. While bit 7 is 0 the strobe is ignored.
- R10: A read of index 15 returns the current byte. That byte then becomes 0x80, and status bit 5 is set to 1.
- R11: Reads of indexes 4 to 7 return bytes 0 to 3 of the header word, where byte 0 is bits [31:24]. When control-1 bit 0 is 1, they return the same bytes of the sub-header word instead.
- R12: Once DEC_HOLD clocks have passed since the last accepted decoder strobe, an access to index 1 sets status bit 5 to 1, and a read shows the value already set. An access made earlier leaves the bit unchanged.
- R13: A write to index 15 restores every register to its reset value and returns the pointer to 0.
- R14: A write to control-0 (index 10) sets index 12 to (data AND 0x80). Control-0 bit 4 selects how index 14 is formed. When bit 4 is 0, index 14 reads control-1 AND 0x0C. When bit 4 is 1, it reads control-1 bit 3 at bit 3 and sub-header byte 2 bit 5 at bit 2. Index 14 is recomputed on every write to control-0 or control-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idx_load | input | 1 | Load the index pointer |
| idx_val | input | IDX_W | Value loaded into the pointer |
| wr_en | input | 1 | Write strobe for the selected register |
| rd_en | input | 1 | Read strobe for the selected register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| xfer_start | output | 1 | One-clock transfer start pulse |
| xfer_done | input | 1 | Transfer finished strobe |
| xfer_cnt | output | 12 | Programmed byte count |
| xfer_addr | output | 16 | Programmed start address |
| dec_strobe | input | 1 | Decoder block ready |
| dec_hdr | input | 32 | Block header word |
| dec_sub | input | 32 | Block sub-header word |
| host_en | input | 1 | Host-side interrupt enable |
| host_clr | input | 1 | Clear the pending level |
| irq_n | output | 1 | Active-low combined interrupt |
| host_pend | output | 1 | Pending host interrupt level |

## Verification
`rdata` is a combinational function of the pointer and the register state. The bench therefore samples it one time unit after raising `rd_en`, before the edge that applies the side effects of the read. Register updates, `xfer_start` and `irq_n` take effect at the edge that accepts a strobe, so the bench checks them one time unit after that edge. `host_pend` needs one more edge behind `irq_n`, and it is checked only after at least one further clock has passed. The decoder expiry check counts clocks from the strobe edge, and it samples both well inside the DEC_HOLD window and well past it.

// File: rtl/disc_reg_pkg.sv
package disc_reg_pkg;

    localparam int unsigned DW = 8;

    // write-side indexes
    localparam logic [4:0] WI_IFACE  = 5'd1;
    localparam logic [4:0] WI_CNT_LO = 5'd2;
    localparam logic [4:0] WI_CNT_HI = 5'd3;
    localparam logic [4:0] WI_ADR_LO = 5'd4;
    localparam logic [4:0] WI_ADR_HI = 5'd5;
    localparam logic [4:0] WI_TRIG   = 5'd6;
    localparam logic [4:0] WI_ACK    = 5'd7;
    localparam logic [4:0] WI_WA_LO  = 5'd8;
    localparam logic [4:0] WI_WA_HI  = 5'd9;
    localparam logic [4:0] WI_CTL0   = 5'd10;
    localparam logic [4:0] WI_CTL1   = 5'd11;
    localparam logic [4:0] WI_PT_LO  = 5'd12;
    localparam logic [4:0] WI_PT_HI  = 5'd13;
    localparam logic [4:0] WI_RESET  = 5'd15;

    // read-side indexes
    localparam logic [4:0] RI_STAT   = 5'd1;
    localparam logic [4:0] RI_CNT_LO = 5'd2;
    localparam logic [4:0] RI_CNT_HI = 5'd3;
    localparam logic [4:0] RI_HDR0   = 5'd4;
    localparam logic [4:0] RI_HDR1   = 5'd5;
    localparam logic [4:0] RI_HDR2   = 5'd6;
    localparam logic [4:0] RI_HDR3   = 5'd7;
    localparam logic [4:0] RI_PT_LO  = 5'd8;
    localparam logic [4:0] RI_PT_HI  = 5'd9;
    localparam logic [4:0] RI_WA_LO  = 5'd10;
    localparam logic [4:0] RI_WA_HI  = 5'd11;
    localparam logic [4:0] RI_DST0   = 5'd12;
    localparam logic [4:0] RI_DST1   = 5'd13;
    localparam logic [4:0] RI_DST2   = 5'd14;
    localparam logic [4:0] RI_DST3   = 5'd15;

    // bit positions
    localparam int ST_XEND  = 6;
    localparam int ST_DEC   = 5;
    localparam int ST_BUSY  = 3;
    localparam int ST_XEN   = 2;
    localparam int IF_XEND_IE = 6;
    localparam int IF_DEC_IE  = 5;
    localparam int IF_DOUT    = 1;
    localparam int C0_DECEN = 7;
    localparam int C0_AUTO  = 4;
    localparam int C1_SUBSEL = 0;

    typedef struct packed {
        logic [DW-1:0] status;
        logic [DW-1:0] ifctl;
        logic [DW-1:0] cnt_lo;
        logic [DW-1:0] cnt_hi;
        logic [DW-1:0] adr_lo;
        logic [DW-1:0] adr_hi;
        logic [DW-1:0] wa_lo;
        logic [DW-1:0] wa_hi;
        logic [DW-1:0] pt_lo;
        logic [DW-1:0] pt_hi;
        logic [DW-1:0] ctl0;
        logic [DW-1:0] ctl1;
        logic [DW-1:0] dst0;
        logic [DW-1:0] dst2;
        logic [DW-1:0] dst3;
        logic [31:0]   hdr;
        logic [31:0]   sub;
    } bank_t;

    function automatic bank_t bank_defaults();
        bank_t b;
        b        = '0;
        b.status = 8'hFF;
        b.dst3   = 8'h80;
        b.hdr    = 32'h0000_0001;
        return b;
    endfunction

    function automatic logic [DW-1:0] word_byte(input logic [31:0] w, input logic [1:0] k);
        return w[31 - 8*k -: 8];
    endfunction

    function automatic logic [DW-1:0] mode_byte(input logic autom, input logic [DW-1:0] c1,
                                                input logic [DW-1:0] sub_b2);
        if (autom) return {4'b0, c1[3], sub_b2[5], 2'b00};
        return c1 & 8'h0C;
    endfunction

endpackage

// File: rtl/disc_idx_ptr.sv
module disc_idx_ptr #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             load,
    input  logic [IDX_W-1:0] load_val,
    input  logic             step,
    output logic [IDX_W-1:0] ptr
);
    localparam logic [IDX_W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst || clear)          ptr <= '0;
        else if (load)             ptr <= load_val;
        else if (step && ptr != 0) ptr <= ptr + 1'b1;
    end

    // R1
    ptr_park_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !load && ptr == 0) |=> ptr == 0);

    // R1
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !load && !clear && ptr == TOP) |=> ptr == 0);
endmodule

// File: rtl/disc_dec_timer.sv
module disc_dec_timer #(
    parameter int HOLD = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic expired
);
    localparam int CW = $clog2(HOLD + 1);
    localparam logic [CW-1:0] LOADV = CW'(HOLD);

    logic [CW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst)            left <= '0;
        else if (start)     left <= LOADV;
        else if (left != 0) left <= left - 1'b1;
    end

    assign expired = (left == 0);

    // R12
    hold_fresh_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> !expired);
endmodule

// File: rtl/disc_irq_gen.sv
module disc_irq_gen (
    input  logic clk,
    input  logic rst,
    input  logic src_any,
    input  logic host_en,
    input  logic host_clr,
    output logic pend
);
    logic was_any;

    always_ff @(posedge clk) begin
        if (rst) begin
            was_any <= 1'b0;
            pend    <= 1'b0;
        end else begin
            was_any <= src_any;
            if (host_clr)                           pend <= 1'b0;
            else if (src_any && !was_any && host_en) pend <= 1'b1;
        end
    end

    // R4
    pend_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pend) |-> $past(host_en));

    // R4
    pend_clr_chk: assert property (@(posedge clk) disable iff (rst)
        host_clr |=> !pend);
endmodule

// File: rtl/disc_reg_bank.sv
module disc_reg_bank
    import disc_reg_pkg::*;
#(
    parameter int IDX_W    = 4,
    parameter int DEC_HOLD = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             idx_load,
    input  logic [IDX_W-1:0] idx_val,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    output logic             xfer_start,
    input  logic             xfer_done,
    output logic [11:0]      xfer_cnt,
    output logic [15:0]      xfer_addr,
    input  logic             dec_strobe,
    input  logic [31:0]      dec_hdr,
    input  logic [31:0]      dec_sub,
    input  logic             host_en,
    input  logic             host_clr,
    output logic             irq_n,
    output logic             host_pend
);
    bank_t            r;
    logic [IDX_W-1:0] ptr;
    logic [4:0]       ix;
    logic             soft_rst;
    logic             dec_take;
    logic             dec_expired;
    logic             src_any;
    logic [1:0]       src_vec;

    assign ix       = 5'(ptr);
    assign soft_rst = wr_en && ix == WI_RESET;
    assign dec_take = dec_strobe && r.ctl0[C0_DECEN];

    disc_idx_ptr #(.IDX_W(IDX_W)) u_ptr (
        .clk(clk), .rst(rst), .clear(soft_rst), .load(idx_load),
        .load_val(idx_val), .step(wr_en || rd_en), .ptr(ptr)
    );

    disc_dec_timer #(.HOLD(DEC_HOLD)) u_timer (
        .clk(clk), .rst(rst || soft_rst), .start(dec_take), .expired(dec_expired)
    );

    assign src_vec = ~r.status[ST_XEND:ST_DEC] & r.ifctl[IF_XEND_IE:IF_DEC_IE];
    assign src_any = |src_vec;
    assign irq_n   = ~src_any;

    disc_irq_gen u_irq (
        .clk(clk), .rst(rst), .src_any(src_any), .host_en(host_en),
        .host_clr(host_clr), .pend(host_pend)
    );

    assign xfer_cnt  = {r.cnt_hi[3:0], r.cnt_lo};
    assign xfer_addr = {r.adr_hi, r.adr_lo};

    logic [31:0] hsel;
    assign hsel = r.ctl1[C1_SUBSEL] ? r.sub : r.hdr;

    always_comb begin
        unique case (ix)
            RI_STAT:   rdata = r.status | (dec_expired ? 8'h20 : 8'h00);
            RI_CNT_LO: rdata = r.cnt_lo;
            RI_CNT_HI: rdata = r.cnt_hi;
            RI_HDR0:   rdata = word_byte(hsel, 2'd0);
            RI_HDR1:   rdata = word_byte(hsel, 2'd1);
            RI_HDR2:   rdata = word_byte(hsel, 2'd2);
            RI_HDR3:   rdata = word_byte(hsel, 2'd3);
            RI_PT_LO:  rdata = r.pt_lo;
            RI_PT_HI:  rdata = r.pt_hi;
            RI_WA_LO:  rdata = r.wa_lo;
            RI_WA_HI:  rdata = r.wa_hi;
            RI_DST0:   rdata = r.dst0;
            RI_DST1:   rdata = 8'h00;
            RI_DST2:   rdata = r.dst2;
            RI_DST3:   rdata = r.dst3;
            default:   rdata = 8'hFF;
        endcase
    end

    always_ff @(posedge clk) begin
        xfer_start <= 1'b0;
        if (rst || soft_rst) begin
            r <= bank_defaults();
        end else begin
            if (wr_en) begin
                unique case (ix)
                    WI_IFACE: begin
                        r.ifctl <= wdata;
                        if (dec_expired) r.status[ST_DEC] <= 1'b1;
                        if (!wdata[IF_DOUT]) begin
                            r.status[ST_BUSY] <= 1'b1;
                            r.status[ST_XEN]  <= 1'b1;
                        end
                    end
                    WI_CNT_LO: r.cnt_lo <= wdata;
                    WI_CNT_HI: r.cnt_hi <= {4'b0, wdata[3:0]};
                    WI_ADR_LO: r.adr_lo <= wdata;
                    WI_ADR_HI: r.adr_hi <= wdata;
                    WI_TRIG: begin
                        if (r.ifctl[IF_DOUT]) begin
                            r.status[ST_BUSY] <= 1'b0;
                            r.status[ST_XEN]  <= 1'b0;
                            xfer_start        <= 1'b1;
                        end
                    end
                    WI_ACK:   r.status[ST_XEND] <= 1'b1;
                    WI_WA_LO: r.wa_lo <= wdata;
                    WI_WA_HI: r.wa_hi <= wdata;
                    WI_CTL0: begin
                        r.ctl0 <= wdata;
                        r.dst0 <= wdata & 8'h80;
                        r.dst2 <= mode_byte(wdata[C0_AUTO], r.ctl1, r.sub[15:8]);
                    end
                    WI_CTL1: begin
                        r.ctl1 <= wdata;
                        r.dst2 <= mode_byte(r.ctl0[C0_AUTO], wdata, r.sub[15:8]);
                    end
                    WI_PT_LO: r.pt_lo <= wdata;
                    WI_PT_HI: r.pt_hi <= wdata;
                    default: ;
                endcase
            end
            if (rd_en) begin
                if (ix == RI_STAT && dec_expired) r.status[ST_DEC] <= 1'b1;
                if (ix == RI_DST3) begin
                    r.dst3           <= 8'h80;
                    r.status[ST_DEC] <= 1'b1;
                end
            end
            if (xfer_done) begin
                r.status[ST_BUSY] <= 1'b1;
                r.status[ST_XEN]  <= 1'b1;
                r.status[ST_XEND] <= 1'b0;
            end
            if (dec_take) begin
                r.hdr            <= dec_hdr;
                r.sub            <= dec_sub;
                r.dst3           <= 8'h00;
                r.status[ST_DEC] <= 1'b0;
            end
        end
    end

    // R6
    abort_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ix == WI_IFACE && !wdata[IF_DOUT]) |=> r.status[ST_BUSY] && r.status[ST_XEN]);

    // R7
    ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ix == WI_ACK && !xfer_done) |=> r.status[ST_XEND]);

    // R10
    dst3_restore_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && ix == RI_DST3 && !dec_take) |=> (r.dst3 == 8'h80) && r.status[ST_DEC]);

    // R8
    cnt_hi_nibble_chk: assert property (@(posedge clk) disable iff (rst)
        r.cnt_hi[7:4] == 4'h0);

    // R5
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_start && !$past(xfer_done)) |-> !r.status[ST_BUSY]);
endmodule

// File: tb/disc_reg_bank_test.sv
module disc_reg_bank_test;
    localparam int CLK_P = 10;
    localparam int IDX_W = 4;
    localparam int HOLD  = 20;

    logic clk = 0, rst = 1;
    logic idx_load = 0, wr_en = 0, rd_en = 0;
    logic [IDX_W-1:0] idx_val = '0;
    logic [7:0] wdata = '0, rdata;
    logic xfer_start, xfer_done = 0;
    logic [11:0] xfer_cnt;
    logic [15:0] xfer_addr;
    logic dec_strobe = 0;
    logic [31:0] dec_hdr = '0, dec_sub = '0;
    logic host_en = 0, host_clr = 0, irq_n, host_pend;

    int checks = 0, errors = 0;
    bit finished = 0;
    logic [7:0] v;

    always #(CLK_P/2) clk = ~clk;

    disc_reg_bank #(.IDX_W(IDX_W), .DEC_HOLD(HOLD)) uut (
        .clk(clk), .rst(rst), .idx_load(idx_load), .idx_val(idx_val),
        .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
        .xfer_start(xfer_start), .xfer_done(xfer_done), .xfer_cnt(xfer_cnt),
        .xfer_addr(xfer_addr), .dec_strobe(dec_strobe), .dec_hdr(dec_hdr),
        .dec_sub(dec_sub), .host_en(host_en), .host_clr(host_clr),
        .irq_n(irq_n), .host_pend(host_pend)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic setidx(input int i);
        idx_load = 1; idx_val = IDX_W'(i); tick(); idx_load = 0;
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1; wdata = d; tick(); wr_en = 0;
    endtask

    task automatic rd(output logic [7:0] d);
        rd_en = 1; #1 d = rdata; tick(); rd_en = 0;
    endtask

    task automatic pulse_done();
        xfer_done = 1; tick(); xfer_done = 0;
    endtask

    task automatic pulse_dec(input logic [31:0] h, input logic [31:0] s);
        dec_strobe = 1; dec_hdr = h; dec_sub = s; tick(); dec_strobe = 0;
    endtask

    function automatic logic [7:0] reset_val(input int i);
        case (i)
            0: return 8'hFF;
            1: return 8'hFF;
            7: return 8'h01;
            15: return 8'h80;
            default: return 8'h00;
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        tick();

        // R2 reset outputs
        chk("R2 irq_n", irq_n, 1);
        chk("R2 host_pend", host_pend, 0);
        chk("R2 xfer_start", xfer_start, 0);
        chk("R2 xfer_cnt", xfer_cnt, 0);

        // R1 parked at index 0; R8 index 0 reads FF
        rd(v); chk("R8 idx0 read", v, 8'hFF);
        rd(v); chk("R1 parked idx0", v, 8'hFF);

        // R1/R2 sweep of every index with auto-increment and wrap
        setidx(1);
        for (int i = 1; i <= 17; i++) begin
            rd(v);
            chk($sformatf("R1 R2 sweep idx%0d", i % 16), v, reset_val(i % 16));
        end

        // R8 programming through sequential writes
        setidx(1);
        wr(8'h02); wr(8'h5A); wr(8'hF3); wr(8'h34); wr(8'h12);
        chk("R8 xfer_cnt", xfer_cnt, 12'h35A);
        chk("R8 xfer_addr", xfer_addr, 16'h1234);
        wr(8'h00);
        chk("R5 start pulse", xfer_start, 1);
        tick();
        chk("R5 start one clock", xfer_start, 0);
        setidx(1); rd(v); chk("R5 busy flags", v, 8'hF3);
        setidx(3); rd(v); chk("R8 cnt_hi nibble", v, 8'h03);

        // R6 abort, then R5 trigger ignored
        setidx(1); wr(8'h00);
        setidx(1); rd(v); chk("R6 abort flags", v, 8'hFF);
        setidx(6); wr(8'h00);
        chk("R5 ignored start", xfer_start, 0);
        setidx(1); rd(v); chk("R5 ignored status", v, 8'hFF);

        // R7 / R4 transfer-end interrupt
        host_en = 1;
        setidx(1); wr(8'h42);
        setidx(6); wr(8'h00);
        pulse_done();
        chk("R3 irq_n xend", irq_n, 0);
        setidx(1); rd(v); chk("R7 done status", v, 8'hBF);
        chk("R4 pend set", host_pend, 1);
        host_clr = 1; tick(); host_clr = 0;
        chk("R4 pend cleared", host_pend, 0);
        setidx(7); wr(8'h00);
        chk("R7 ack irq_n", irq_n, 1);
        setidx(1); rd(v); chk("R7 ack status", v, 8'hFF);
        host_en = 0;
        pulse_done();
        chk("R3 irq_n again", irq_n, 0);
        tick(); tick();
        chk("R4 gated by host_en", host_pend, 0);
        setidx(7); wr(8'h00);
        host_en = 1;

        // R3 sweep of enable combinations with both sources
        setidx(10); wr(8'h80);
        for (int e = 0; e < 4; e++) begin
            setidx(1); wr(8'((e << 5) | 8'h02));
            pulse_done();
            pulse_dec(32'hA1B2C3D4, 32'h11221344);
            chk($sformatf("R3 both e=%0d", e), irq_n, (e != 0) ? 1'b0 : 1'b1);
            setidx(7); wr(8'h00);
            chk($sformatf("R3 dec only e=%0d", e), irq_n, e[0] ? 1'b0 : 1'b1);
            setidx(15); rd(v);
            chk($sformatf("R9 dst3 e=%0d", e), v, 8'h00);
            chk($sformatf("R10 irq clear e=%0d", e), irq_n, 1);
            setidx(15); rd(v);
            chk($sformatf("R10 dst3 restored e=%0d", e), v, 8'h80);
        end

        // R11 header / sub-header selection
        setidx(4);
        for (int k = 0; k < 4; k++) begin
            rd(v); chk($sformatf("R11 hdr byte%0d", k), v, 8'(32'hA1B2C3D4 >> (24 - 8*k)));
        end
        setidx(11); wr(8'h0D);
        setidx(14); rd(v); chk("R14 dst2 manual", v, 8'h0C);
        setidx(4);
        for (int k = 0; k < 4; k++) begin
            rd(v); chk($sformatf("R11 sub byte%0d", k), v, 8'(32'h11221344 >> (24 - 8*k)));
        end
        setidx(10); wr(8'h90);
        setidx(12); rd(v); chk("R14 dst0", v, 8'h80);
        rd(v); chk("R8 idx13 zero", v, 8'h00);
        rd(v); chk("R14 dst2 auto", v, 8'h08);

        // R9 strobe ignored with decoding off
        setidx(10); wr(8'h00);
        pulse_dec(32'h55667788, 32'h99AABBCC);
        setidx(15); rd(v); chk("R9 ignored dst3", v, 8'h80);
        setidx(11); wr(8'h00);
        setidx(4); rd(v); chk("R9 ignored hdr", v, 8'hA1);

        // R12 decoder flag expiry
        setidx(10); wr(8'h80);
        pulse_dec(32'h0102_0304, 32'h0);
        tick(); tick(); tick();
        setidx(1); rd(v); chk("R12 not yet expired", v, 8'hDF);
        repeat (HOLD) tick();
        setidx(1); rd(v); chk("R12 expired", v, 8'hFF);

        // R13 soft reset
        setidx(2); wr(8'h77);
        setidx(15); wr(8'h00);
        rd(v); chk("R13 pointer zero", v, 8'hFF);
        setidx(2); rd(v); chk("R13 cnt_lo", v, 8'h00);
        setidx(7); rd(v); chk("R13 hdr3", v, 8'h01);
        setidx(15); rd(v); chk("R13 dst3", v, 8'h80);
        chk("R13 irq_n", irq_n, 1);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule